// File: doc/BRIEF.md
# Pipelined Polynomial Predistorter

The block warps a stream of real fixed-point samples through a polynomial of programmable order before they reach a nonlinear amplifier: y = a0 + a1·x + a2·x² + … + aP·x^P. It takes one sample on every clock and returns one result on every clock. The powers of each sample are built in a chain of registered stages. Each stage adds one weighted power to a running sum that travels alongside its sample. No stage loops, so throughput does not depend on the order.

Coefficients are written one at a time into a staging bank that the datapath does not see. A commit strobe moves the staged set into use. The new set enters the pipeline stage by stage, in step with the first sample that must see it. Every output is therefore computed from one coefficient set only. After reset the block passes samples through unchanged.

Top module: `poly_predist`

## Requirements
- R1: While reset is held, and on the first cycle after it, out_valid is 0 and out_y is 0. After reset the active coefficients are a1 = 1.0 (integer value 2^CF) and every other coefficient 0, so each output equals its input.
- R2: Samples are signed two's complement Q1.(DW-1) and coefficients are signed with CF fraction bits. Rounding adds half an LSB and then shifts right arithmetically. With p = x, the sum starts at s = round(a0·2^(DW-1) >> CF). For i = 1..ORDER the block then computes s = sat(s + sat(round(ai·p >> CF))), and for i < ORDER it also computes p = sat(round(p·x >> (DW-1))). The output is the final s.
- R3: An input accepted with in_valid high gives out_valid high exactly ORDER+1 clock edges later, carrying its result. Back-to-back and gapped valid patterns are both preserved.
- R4: Every power, weighted term and partial sum clips to the range -2^(DW-1) .. 2^(DW-1)-1 instead of wrapping, including at full-scale inputs and coefficients.
- R5: A write with cfg_we high and cfg_idx in 0..ORDER updates the staged coefficient a[cfg_idx] and has no effect on outputs until a commit. A write with cfg_idx greater than ORDER is ignored.
- R6: An accepted commit makes the staged set active for every sample presented after the commit cycle. A sample presented in the same cycle as the commit still uses the old set. No output mixes the two sets. Staging writes made after the commit do not alter the set being brought into use.
- R7: A commit issued during the ORDER cycles after an accepted commit is ignored. The next commit is accepted from the (ORDER+1)th cycle after the accepted one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample qualifier |
| in_x | input | DW | Input sample, signed Q1.(DW-1) |
| cfg_we | input | 1 | Staging coefficient write enable |
| cfg_idx | input | IDX_W | Coefficient index (power) being written |
| cfg_data | input | CW | Coefficient value, CF fraction bits |
| cfg_commit | input | 1 | Make the staged coefficients active |
| out_valid | output | 1 | Output sample qualifier |
| out_y | output | DW | Predistorted sample |

## Verification
The assertions check on every cycle that no partial sum changes sign through overflow and that a power of a non-negative sample stays non-negative. They also check that at most one commit is ever in flight, that a refused commit leaves the launched set untouched, and that each stage's coefficient changes only on its staggered load. Only the bench's scenarios can show the numeric result for each sample, the exact latency under gapped traffic, the cycle boundary at which a new set takes over, and the isolation of staging writes before and after a commit.

// File: rtl/poly_predist_pkg.sv
package poly_predist_pkg;

  // Round half up by shifting right sh bits, then clip to a signed w-bit range.
  function automatic longint shr_round_sat(input longint v, input int sh, input int w);
    longint r;
    longint hi;
    longint lo;
    r  = (sh > 0) ? ((v + (64'sd1 <<< (sh - 1))) >>> sh) : v;
    hi = (64'sd1 <<< (w - 1)) - 64'sd1;
    lo = -(64'sd1 <<< (w - 1));
    if (r > hi) r = hi;
    if (r < lo) r = lo;
    return r;
  endfunction

endpackage

// File: rtl/pd_coef_bank.sv
module pd_coef_bank #(
  parameter int ORDER = 4,
  parameter int CW    = 16,
  parameter int CF    = 12,
  parameter int IDX_W = 3
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   cfg_we,
  input  logic [IDX_W-1:0]       cfg_idx,
  input  logic [CW-1:0]          cfg_data,
  input  logic                   cfg_commit,
  output logic [ORDER:0][CW-1:0] live_o
);

  localparam logic [CW-1:0] UNITY = CW'(1) << CF;

  logic [ORDER:0][CW-1:0] staged;
  logic [ORDER:1][CW-1:0] launch;
  logic [ORDER-1:0]       pending;
  logic                   busy;
  logic                   accept;

  assign busy   = |pending;
  assign accept = cfg_commit && !busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k <= ORDER; k++) begin
        staged[k] <= (k == 1) ? UNITY : '0;
        live_o[k] <= (k == 1) ? UNITY : '0;
      end
      for (int k = 1; k <= ORDER; k++) launch[k] <= (k == 1) ? UNITY : '0;
      pending <= '0;
    end else begin
      if (cfg_we && (int'(cfg_idx) <= ORDER)) staged[cfg_idx] <= cfg_data;
      pending <= {pending[ORDER-2:0], accept};
      if (accept) begin
        live_o[0] <= staged[0];
        for (int k = 1; k <= ORDER; k++) launch[k] <= staged[k];
      end
      for (int k = 1; k <= ORDER; k++)
        if (pending[k-1]) live_o[k] <= launch[k];
    end
  end

  // R7: an accepted commit is in flight alone
  assert_single_flight_R7: assert property (@(posedge clk) disable iff (rst)
    $onehot0(pending));

  assert_refused_commit_R7: assert property (@(posedge clk) disable iff (rst)
    (cfg_commit && busy) |=> $stable(launch));

  // R6: launch stage loaded right after an accepted commit
  assert_commit_launch_R6: assert property (@(posedge clk) disable iff (rst)
    accept |=> pending[0]);

  generate
    for (genvar k = 1; k <= ORDER; k++) begin : g_hold
      assert_coef_hold_R6: assert property (@(posedge clk) disable iff (rst)
        !pending[k-1] |=> $stable(live_o[k]));
    end
  endgenerate

endmodule

// File: rtl/pd_power.sv
module pd_power
  import poly_predist_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic signed [DW-1:0] pw_i,
  input  logic signed [DW-1:0] x_i,
  output logic signed [DW-1:0] pw_o
);

  logic signed [DW-1:0] next_pw;

  always_comb
    next_pw = DW'(shr_round_sat(longint'(pw_i) * longint'(x_i), DW - 1, DW));

  always_ff @(posedge clk) begin
    if (rst) pw_o <= '0;
    else     pw_o <= next_pw;
  end

  assert_power_sign_R4: assert property (@(posedge clk) disable iff (rst)
    (pw_i >= 0 && x_i >= 0) |=> (pw_o >= 0));

endmodule

// File: rtl/pd_term_acc.sv
module pd_term_acc
  import poly_predist_pkg::*;
#(
  parameter int DW = 16,
  parameter int CW = 16,
  parameter int CF = 12
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic signed [CW-1:0] coef_i,
  input  logic signed [DW-1:0] pw_i,
  input  logic signed [DW-1:0] acc_i,
  output logic signed [DW-1:0] acc_o
);

  logic signed [DW-1:0] term;
  logic signed [DW-1:0] sum_c;

  always_comb begin
    term  = DW'(shr_round_sat(longint'(coef_i) * longint'(pw_i), CF, DW));
    sum_c = DW'(shr_round_sat(longint'(acc_i) + longint'(term), 0, DW));
  end

  always_ff @(posedge clk) begin
    if (rst) acc_o <= '0;
    else     acc_o <= sum_c;
  end

  assert_no_wrap_pos_R4: assert property (@(posedge clk) disable iff (rst)
    (acc_i >= 0 && term >= 0) |=> (acc_o >= 0));

  assert_no_wrap_neg_R4: assert property (@(posedge clk) disable iff (rst)
    (acc_i < 0 && term < 0) |=> (acc_o < 0));

endmodule

// File: rtl/poly_predist.sv
module poly_predist
  import poly_predist_pkg::*;
#(
  parameter int ORDER = 4,
  parameter int DW    = 16,
  parameter int CW    = 16,
  parameter int CF    = 12,
  parameter int IDX_W = $clog2(ORDER + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [DW-1:0]    in_x,
  input  logic             cfg_we,
  input  logic [IDX_W-1:0] cfg_idx,
  input  logic [CW-1:0]    cfg_data,
  input  logic             cfg_commit,
  output logic             out_valid,
  output logic [DW-1:0]    out_y
);

  localparam int LAT = ORDER + 1;

  logic [ORDER:0][CW-1:0] coef;
  logic signed [DW-1:0]   pw  [0:ORDER-1];
  logic signed [DW-1:0]   xd  [0:ORDER-2];
  logic signed [DW-1:0]   acc [0:ORDER];
  logic [LAT-1:0]         vd;
  logic signed [DW-1:0]   bias;

  pd_coef_bank #(.ORDER(ORDER), .CW(CW), .CF(CF), .IDX_W(IDX_W)) coef_bank_i (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_data(cfg_data), .cfg_commit(cfg_commit), .live_o(coef)
  );

  always_comb
    bias = DW'(shr_round_sat(longint'($signed(coef[0])) <<< (DW - 1), CF, DW));

  // Head stage: register sample, first power and constant term
  always_ff @(posedge clk) begin
    if (rst) begin
      pw[0]  <= '0;
      xd[0]  <= '0;
      acc[0] <= '0;
      vd     <= '0;
    end else begin
      pw[0]  <= $signed(in_x);
      xd[0]  <= $signed(in_x);
      acc[0] <= bias;
      vd     <= {vd[LAT-2:0], in_valid};
    end
  end

  generate
    for (genvar k = 1; k <= ORDER - 2; k++) begin : g_xdly
      always_ff @(posedge clk) begin
        if (rst) xd[k] <= '0;
        else     xd[k] <= xd[k-1];
      end
    end

    for (genvar k = 1; k <= ORDER - 1; k++) begin : g_pow
      pd_power #(.DW(DW)) pow_i (
        .clk(clk), .rst(rst), .pw_i(pw[k-1]), .x_i(xd[k-1]), .pw_o(pw[k])
      );
    end

    for (genvar k = 1; k <= ORDER; k++) begin : g_term
      pd_term_acc #(.DW(DW), .CW(CW), .CF(CF)) term_i (
        .clk(clk), .rst(rst), .coef_i(coef[k]), .pw_i(pw[k-1]),
        .acc_i(acc[k-1]), .acc_o(acc[k])
      );
    end
  endgenerate

  assign out_valid = vd[LAT-1];
  assign out_y     = acc[ORDER];

endmodule

// File: tb/poly_predist_tb_top.sv
module poly_predist_tb_top;

  localparam int ORDER = 4;
  localparam int DW    = 16;
  localparam int CW    = 16;
  localparam int CF    = 12;
  localparam int IW    = 3;
  localparam int LAT   = ORDER + 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [DW-1:0] in_x = '0;
  logic cfg_we = 1'b0;
  logic [IW-1:0] cfg_idx = '0;
  logic [CW-1:0] cfg_data = '0;
  logic cfg_commit = 1'b0;
  logic out_valid;
  logic [DW-1:0] out_y;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;
  string cur_req = "R1";

  longint act [0:ORDER];
  longint shd [0:ORDER];
  int     busy_cnt = 0;
  bit     qv [$];
  longint qy [$];

  always #5 clk = ~clk;

  poly_predist #(.ORDER(ORDER), .DW(DW), .CW(CW), .CF(CF)) dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_x(in_x),
    .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_data(cfg_data),
    .cfg_commit(cfg_commit), .out_valid(out_valid), .out_y(out_y)
  );

  function automatic longint clip(input longint v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  function automatic longint rsh(input longint v, input int sh);
    return (v + (64'sd1 <<< (sh - 1))) >>> sh;
  endfunction

  function automatic longint ref_poly(input longint x);
    longint p;
    longint s;
    p = x;
    s = clip(rsh(act[0] * 32768, CF));
    for (int i = 1; i <= ORDER; i++) begin
      s = clip(s + clip(rsh(act[i] * p, CF)));
      if (i < ORDER) p = clip(rsh(p * x, DW - 1));
    end
    return s;
  endfunction

  task automatic check(input string req, input longint got, input longint exp, input string what);
    n_cmp++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, got, exp);
    end
  endtask

  task automatic step(input bit v, input longint x, input bit we, input int idx,
                      input longint d, input bit cm);
    bit ev;
    longint ey;
    @(negedge clk);
    if (qv.size() == LAT) begin
      ev = qv.pop_front();
      ey = qy.pop_front();
      check("R3", longint'(out_valid), longint'(ev), "out_valid");
      if (ev) check(cur_req, longint'($signed(out_y)), ey, "out_y");
    end else begin
      check("R3", longint'(out_valid), 0, "out_valid during fill");
    end
    in_valid   = v;
    in_x       = DW'(x);
    cfg_we     = we;
    cfg_idx    = IW'(idx);
    cfg_data   = CW'(d);
    cfg_commit = cm;
    qv.push_back(v);
    qy.push_back(ref_poly(x));
    if (cm && busy_cnt == 0) begin
      for (int i = 0; i <= ORDER; i++) act[i] = shd[i];
      busy_cnt = ORDER;
    end else if (busy_cnt > 0) begin
      busy_cnt--;
    end
    if (we && idx <= ORDER) shd[idx] = d;
  endtask

  function automatic longint rnd_x();
    return longint'($signed(16'($urandom)));
  endfunction

  task automatic stream(input int n, input int gap_mod);
    for (int i = 0; i < n; i++)
      step((gap_mod == 0) || (i % gap_mod != 0), rnd_x(), 0, 0, 0, 0);
  endtask

  task automatic stage_set(input longint c0, input longint c1, input longint c2,
                           input longint c3, input longint c4);
    step(1, rnd_x(), 1, 0, c0, 0);
    step(1, rnd_x(), 1, 1, c1, 0);
    step(1, rnd_x(), 1, 2, c2, 0);
    step(1, rnd_x(), 1, 3, c3, 0);
    step(1, rnd_x(), 1, 4, c4, 0);
  endtask

  initial begin
    for (int i = 0; i <= ORDER; i++) begin
      act[i] = (i == 1) ? 4096 : 0;
      shd[i] = act[i];
    end
    in_valid = 1'b1;
    in_x = 16'h7fff;
    repeat (3) @(negedge clk);
    check("R1", longint'(out_valid), 0, "out_valid in reset");
    check("R1", longint'(out_y), 0, "out_y in reset");
    rst = 1'b0;
    in_valid = 1'b0;
    @(negedge clk);
    check("R1", longint'(out_valid), 0, "out_valid after reset");
    check("R1", longint'(out_y), 0, "out_y after reset");

    // R1: identity pass-through from reset coefficients
    cur_req = "R1";
    stream(20, 0);
    step(1, 32767, 0, 0, 0, 0);
    step(1, -32768, 0, 0, 0, 0);

    // R5: staged writes and out-of-range index must not show at the output
    cur_req = "R5";
    stage_set(512, 3500, -1200, 800, -300);
    step(1, rnd_x(), 1, 5, 32767, 0);
    step(1, rnd_x(), 1, 7, -32768, 0);
    stream(15, 0);

    // R2 / R3: commit, then back-to-back and gapped traffic
    cur_req = "R2";
    step(1, rnd_x(), 0, 0, 0, 1);
    stream(200, 0);
    cur_req = "R3";
    stream(60, 3);
    stream(30, 2);

    // R6: new set staged, commit mid-stream, staging rewritten right after
    cur_req = "R6";
    stage_set(-700, 5000, 900, -2500, 1500);
    step(1, rnd_x(), 0, 0, 0, 1);
    step(1, rnd_x(), 1, 1, -4096, 0);
    step(1, rnd_x(), 1, 2, 3000, 0);

    // R7: commit while the previous one is still propagating is refused
    cur_req = "R7";
    step(1, rnd_x(), 0, 0, 0, 1);
    stream(20, 0);
    step(1, rnd_x(), 0, 0, 0, 1);
    stream(ORDER - 1, 0);
    step(1, rnd_x(), 0, 0, 0, 1);
    step(1, rnd_x(), 0, 0, 0, 1);
    stream(20, 0);

    // R4: full-scale samples and extreme coefficients
    cur_req = "R4";
    stage_set(-32768, 32767, 32767, 32767, 32767);
    step(1, rnd_x(), 0, 0, 0, 1);
    for (int i = 0; i < 40; i++) begin
      longint xv;
      case (i % 4)
        0: xv = 32767;
        1: xv = -32768;
        2: xv = -32767;
        default: xv = rnd_x();
      endcase
      step(1, xv, 0, 0, 0, 0);
    end
    stage_set(32767, -32768, 32767, -32768, 32767);
    step(1, rnd_x(), 0, 0, 0, 1);
    for (int i = 0; i < 40; i++)
      step(1, (i % 2 == 0) ? 32767 : -32768, 0, 0, 0, 0);
    stream(40, 0);

    for (int i = 0; i < LAT + 2; i++) step(0, 0, 0, 0, 0, 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule